// File: doc/BRIEF.md
# Shared Queue-Level Flag Bus Driver

This block sits in each member of a group of up to eight buffer devices whose per-queue status buses are wired together. Two 4-bit buses leave every device. One carries the almost-full state of each queue and the other carries the almost-empty state. Each bit stands for one queue. Because the buses are shared, only one device may place its bits on a bus at a time. The block decides when its own device owns each bus.

Two ownership schemes are available, chosen by a static mode input. In rotating mode, every member of the group keeps an identical turn counter. The counter steps once per clock edge, so ownership passes from device to device in ascending order. In addressed mode, a strobe captures a device number from the upper bits of a port address, and only the device with that number drives the bus. The almost-full bus is sequenced and addressed from the write side on the write clock. The almost-empty bus is sequenced and addressed from the read side on the read clock. The two sides never affect each other.

Top module: `flag_bus_driver`

## Requirements
- R1: An active-low `rst_n` puts both turn counters and both captured addresses at device 0. With `dev_id` nonzero, both drive outputs are low and both buses are 0 right after reset.
- R2: In rotating mode (`direct_mode`=0), `af_drive` is high while the write-side turn counter equals `dev_id`. The counter advances by one on every rising `wclk` edge, so a device owns the bus for exactly one cycle out of every NUM_DEV.
- R3: The turn counter goes from NUM_DEV-1 back to 0, so devices numbered NUM_DEV or above are never given a turn.
- R4: In addressed mode (`direct_mode`=1), a rising edge with the strobe high loads the device number from address bits [4:2]. Address bits [1:0] have no effect. From the next cycle on, the drive output is high exactly when the loaded number equals `dev_id`.
- R5: In addressed mode, an edge with the strobe low leaves the captured device number unchanged, whatever the address bus carries.
- R6: Whenever a drive output is low, all 4 bits of its bus are 0.
- R7: While a drive output is high, bus bit i equals the status input bit i for i < NUM_Q, and bits i >= NUM_Q are 0.
- R8: The almost-empty side (`ae_bus`, `ae_drive`, `rd_addr`, `rd_strobe`) changes state only on `rclk`. The almost-full side (`af_bus`, `af_drive`, `wr_addr`, `wr_strobe`) changes state only on `wclk`.
- R9: The mode input selects the ownership source directly. On a change of `direct_mode`, the drive outputs follow at once from the turn counter or the captured address, and both keep being updated in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock; sequences the almost-full bus |
| rclk | input | 1 | Read-side clock; sequences the almost-empty bus |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| dev_id | input | 3 | Static number of this device in the group |
| direct_mode | input | 1 | 0 = rotating ownership, 1 = addressed ownership |
| queue_af | input | 4 | Almost-full state of each local queue |
| queue_ae | input | 4 | Almost-empty state of each local queue |
| wr_addr | input | 5 | Write port address; bits [4:2] give the device number |
| wr_strobe | input | 1 | Loads the write-side device number on `wclk` |
| rd_addr | input | 5 | Read port address; bits [4:2] give the device number |
| rd_strobe | input | 1 | Loads the read-side device number on `rclk` |
| af_bus | output | 4 | Almost-full bus bits driven by this device |
| af_drive | output | 1 | High while this device owns the almost-full bus |
| ae_bus | output | 4 | Almost-empty bus bits driven by this device |
| ae_drive | output | 1 | High while this device owns the almost-empty bus |

## Verification
A turn counter that is off by one, or that wraps at the wrong count, moves this device's ownership slot. The slot then appears at the ports within one rotation of NUM_DEV edges, as a drive pulse in the wrong cycle. A captured address that is loaded without a strobe, or that takes the low address bits, changes `af_drive` or `ae_drive` on the cycle after the bad capture. A clock crossing between the two sides shows up as soon as the read clock is held while the write clock runs, because the almost-empty owner then moves when it should not.

// File: rtl/flag_bus_driver.sv
module flag_bus_driver #(
  parameter int NUM_DEV = 8,
  parameter int NUM_Q   = 4,
  parameter int DEV_W   = 3,
  parameter int QSEL_W  = 2,
  parameter int BUS_W   = 4
) (
  input  logic               wclk,
  input  logic               rclk,
  input  logic               rst_n,
  input  logic [DEV_W-1:0]   dev_id,
  input  logic               direct_mode,
  input  logic [BUS_W-1:0]   queue_af,
  input  logic [BUS_W-1:0]   queue_ae,
  input  logic [DEV_W+QSEL_W-1:0] wr_addr,
  input  logic               wr_strobe,
  input  logic [DEV_W+QSEL_W-1:0] rd_addr,
  input  logic               rd_strobe,
  output logic [BUS_W-1:0]   af_bus,
  output logic               af_drive,
  output logic [BUS_W-1:0]   ae_bus,
  output logic               ae_drive
);
  localparam int ADDR_W = DEV_W + QSEL_W;
  localparam logic [DEV_W-1:0] LAST  = DEV_W'(NUM_DEV - 1);
  localparam logic [BUS_W-1:0] QMASK = BUS_W'((1 << NUM_Q) - 1);

  logic [DEV_W-1:0] w_turn, r_turn;
  logic [DEV_W-1:0] w_sel,  r_sel;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      w_turn <= '0;
      w_sel  <= '0;
    end else begin
      w_turn <= (w_turn == LAST) ? '0 : w_turn + 1'b1;
      if (wr_strobe) w_sel <= wr_addr[ADDR_W-1:QSEL_W];
    end

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      r_turn <= '0;
      r_sel  <= '0;
    end else begin
      r_turn <= (r_turn == LAST) ? '0 : r_turn + 1'b1;
      if (rd_strobe) r_sel <= rd_addr[ADDR_W-1:QSEL_W];
    end

  logic unused_low_addr;
  assign unused_low_addr = ^{wr_addr[QSEL_W-1:0], rd_addr[QSEL_W-1:0]};

  assign af_drive = direct_mode ? (w_sel == dev_id) : (w_turn == dev_id);
  assign ae_drive = direct_mode ? (r_sel == dev_id) : (r_turn == dev_id);
  assign af_bus   = af_drive ? (queue_af & QMASK) : '0;
  assign ae_bus   = ae_drive ? (queue_ae & QMASK) : '0;
endmodule

// File: rtl/flag_bus_driver_chk.sv
module flag_bus_driver_chk #(
  parameter int NUM_DEV = 8,
  parameter int NUM_Q   = 4,
  parameter int DEV_W   = 3,
  parameter int QSEL_W  = 2,
  parameter int BUS_W   = 4
) (
  input logic                    wclk,
  input logic                    rclk,
  input logic                    rst_n,
  input logic [DEV_W-1:0]        dev_id,
  input logic                    direct_mode,
  input logic [DEV_W+QSEL_W-1:0] wr_addr,
  input logic                    wr_strobe,
  input logic [DEV_W+QSEL_W-1:0] rd_addr,
  input logic                    rd_strobe,
  input logic [BUS_W-1:0]        af_bus,
  input logic                    af_drive,
  input logic [BUS_W-1:0]        ae_bus,
  input logic                    ae_drive
);
  localparam int ADDR_W = DEV_W + QSEL_W;
  localparam logic [BUS_W-1:0] QMASK = BUS_W'((1 << NUM_Q) - 1);

  assert_af_single_turn_R2: assert property (@(posedge wclk) disable iff (!rst_n)
    (!direct_mode && af_drive && NUM_DEV > 1) |=> (direct_mode || !af_drive));

  assert_ae_single_turn_R2: assert property (@(posedge rclk) disable iff (!rst_n)
    (!direct_mode && ae_drive && NUM_DEV > 1) |=> (direct_mode || !ae_drive));

  assert_af_capture_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    (direct_mode && wr_strobe) |=>
      (!direct_mode || af_drive == ($past(wr_addr[ADDR_W-1:QSEL_W]) == dev_id)));

  assert_ae_capture_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    (direct_mode && rd_strobe) |=>
      (!direct_mode || ae_drive == ($past(rd_addr[ADDR_W-1:QSEL_W]) == dev_id)));

  assert_af_hold_R5: assert property (@(posedge wclk) disable iff (!rst_n)
    (direct_mode && !wr_strobe) |=> (!direct_mode || $stable(af_drive)));

  assert_ae_hold_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    (direct_mode && !rd_strobe) |=> (!direct_mode || $stable(ae_drive)));

  assert_af_quiet_R6: assert property (@(posedge wclk) disable iff (!rst_n)
    (af_bus != '0) |-> af_drive);

  assert_ae_quiet_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    (ae_bus != '0) |-> ae_drive);

  assert_unused_bits_R7: assert property (@(posedge wclk) disable iff (!rst_n)
    ((af_bus & ~QMASK) == '0) && ((ae_bus & ~QMASK) == '0));
endmodule

bind flag_bus_driver flag_bus_driver_chk #(
  .NUM_DEV(NUM_DEV), .NUM_Q(NUM_Q), .DEV_W(DEV_W), .QSEL_W(QSEL_W), .BUS_W(BUS_W)
) i_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .dev_id(dev_id),
  .direct_mode(direct_mode), .wr_addr(wr_addr), .wr_strobe(wr_strobe),
  .rd_addr(rd_addr), .rd_strobe(rd_strobe), .af_bus(af_bus),
  .af_drive(af_drive), .ae_bus(ae_bus), .ae_drive(ae_drive)
);

// File: tb/test_flag_bus_driver.sv
module test_flag_bus_driver;
  localparam int ND = 5;
  localparam int NQ = 3;
  localparam logic [2:0] ID = 3'd3;
  localparam logic [3:0] MASK = 4'b0111;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic direct_mode = 0, wr_strobe = 0, rd_strobe = 0;
  logic [2:0] dev_id = ID;
  logic [3:0] queue_af = '0, queue_ae = '0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [3:0] af_bus, ae_bus;
  logic af_drive, ae_drive;
  logic rd_go = 1;

  flag_bus_driver #(.NUM_DEV(ND), .NUM_Q(NQ)) i_flag_bus_driver (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .dev_id(dev_id),
    .direct_mode(direct_mode), .queue_af(queue_af), .queue_ae(queue_ae),
    .wr_addr(wr_addr), .wr_strobe(wr_strobe), .rd_addr(rd_addr),
    .rd_strobe(rd_strobe), .af_bus(af_bus), .af_drive(af_drive),
    .ae_bus(ae_bus), .ae_drive(ae_drive));

  always #4 wclk = ~wclk;

  initial forever begin
    @(posedge wclk);
    if (rd_go) rclk = 1;
    @(negedge wclk);
    rclk = 0;
  end

  typedef struct {
    logic [3:0] af; logic afd; logic [3:0] ae; logic aed; string tag;
  } exp_t;
  exp_t sb[$];
  int checks = 0, fails = 0;
  int m_wcnt = 0, m_wsel = 0, m_rcnt = 0, m_rsel = 0;
  bit done = 0;

  function automatic void push_exp(string tag);
    exp_t e;
    e.afd = direct_mode ? (m_wsel == ID) : (m_wcnt == ID);
    e.aed = direct_mode ? (m_rsel == ID) : (m_rcnt == ID);
    e.af  = e.afd ? (queue_af & MASK) : 4'b0;
    e.ae  = e.aed ? (queue_ae & MASK) : 4'b0;
    e.tag = tag;
    sb.push_back(e);
  endfunction

  task automatic step(input logic mode, input logic [3:0] qaf, input logic [3:0] qae,
                      input logic [4:0] wa, input logic ws, input logic [4:0] ra,
                      input logic rs, input logic go, input string tag);
    @(posedge wclk);
    m_wcnt = (m_wcnt == ND - 1) ? 0 : m_wcnt + 1;
    if (wr_strobe) m_wsel = int'(wr_addr[4:2]);
    if (rd_go) begin
      m_rcnt = (m_rcnt == ND - 1) ? 0 : m_rcnt + 1;
      if (rd_strobe) m_rsel = int'(rd_addr[4:2]);
    end
    #2;
    direct_mode = mode; queue_af = qaf; queue_ae = qae;
    wr_addr = wa; wr_strobe = ws; rd_addr = ra; rd_strobe = rs; rd_go = go;
    push_exp(tag);
  endtask

  initial forever begin
    @(negedge wclk);
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (af_drive !== e.afd || af_bus !== e.af || ae_drive !== e.aed || ae_bus !== e.ae) begin
        fails++;
        $display("FAIL %s: af_drive=%b af_bus=%h ae_drive=%b ae_bus=%h expected %b %h %b %h",
                 e.tag, af_drive, af_bus, ae_drive, ae_bus, e.afd, e.af, e.aed, e.ae);
      end
    end
  end

  initial begin
    #40000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    queue_af = 4'hF; queue_ae = 4'hF;
    repeat (3) @(posedge wclk);
    #2 rst_n = 1;
    push_exp("R1 reset state");
    // rotating mode, both clocks running
    for (int i = 0; i < 14; i++)
      step(1'b0, 4'(i * 5 + 3), 4'(i * 11 + 6), 5'(i), 1'b0, 5'(i), 1'b0, 1'b1,
           "R2 R3 R7 rotating turn and bit mapping");
    // read clock paused on some edges
    for (int i = 0; i < 12; i++)
      step(1'b0, 4'hF, 4'hF, '0, 1'b0, '0, 1'b0, (i % 3 == 0),
           "R8 read side follows rclk only");
    step(1'b0, 4'hF, 4'hF, '0, 1'b0, '0, 1'b0, 1'b1, "R8 realign");
    // addressed mode
    step(1'b1, 4'h5, 4'hA, {3'd3, 2'b01}, 1'b1, {3'd6, 2'b00}, 1'b1, 1'b1, "R9 mode switch to addressed");
    step(1'b1, 4'h5, 4'hA, {3'd5, 2'b11}, 1'b0, {3'd3, 2'b10}, 1'b0, 1'b1, "R4 write capture ignores low bits");
    for (int i = 0; i < 4; i++)
      step(1'b1, 4'(i + 1), 4'(i + 9), {3'(i), 2'b10}, 1'b0, {3'd3, 2'b00}, 1'b0, 1'b1,
           "R5 no strobe keeps selection");
    step(1'b1, 4'h7, 4'h7, {3'd6, 2'b11}, 1'b1, {3'd3, 2'b11}, 1'b1, 1'b1, "R4 R6 strobe moves write owner away");
    step(1'b1, 4'hF, 4'hF, {3'd3, 2'b00}, 1'b0, '0, 1'b0, 1'b1, "R6 R7 write not owner, read owner");
    step(1'b1, 4'hE, 4'h9, {3'd3, 2'b10}, 1'b1, {3'd1, 2'b01}, 1'b1, 1'b0, "R4 R8 read strobe held off by paused rclk");
    step(1'b1, 4'hE, 4'h9, '0, 1'b0, '0, 1'b0, 1'b0, "R8 read capture waits for rclk");
    step(1'b1, 4'hE, 4'h9, '0, 1'b0, {3'd1, 2'b01}, 1'b1, 1'b1, "R4 read capture on rclk");
    step(1'b1, 4'hB, 4'h6, '0, 1'b0, '0, 1'b0, 1'b1, "R4 R6 read owner gone");
    for (int i = 0; i < 7; i++)
      step(1'b0, 4'(i * 3), 4'(i * 7 + 1), '0, 1'b0, '0, 1'b0, 1'b1, "R9 R2 back to rotating");
    @(negedge wclk);
    @(negedge wclk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule